// File: doc/BRIEF.md
# Sequential Shift-Add Integer Multiplier

This block multiplies two 32-bit integers over many clock cycles and returns the full 64-bit product as a high word and a low word. It computes one product bit position per clock. A single 32-bit adder adds the multiplicand into the upper half of a 64-bit working register. The multiplier operand is not held in a register of its own. It is loaded into the lower half of the working register, and one of its bits is used up on every right shift. The multiplicand register stays fixed while the partial product moves right across it.

A one-cycle `start` pulse, given while the unit is idle, captures both operands and the mode. In unsigned mode the unit runs 32 add/shift iterations. In signed mode it works on the operand magnitudes. It runs 31 iterations over the value bits and then one step for the sign position, which adds something only when an operand is the most negative number. A final cycle then negates the 64-bit result if the operand signs differ. `done` pulses for one cycle when the result is ready. The result words hold their value until the next accepted start.

Top module: `shift_add_mul`

## Requirements
- R1: While reset is active and immediately after it, `busy`, `done`, `resHi` and `resLo` are all zero.
- R2: In unsigned mode (`signedMode`=0), when `done` is high, {`resHi`,`resLo`} equals the 64-bit unsigned product of `opA` and `opB` as they were captured at start.
- R3: In unsigned mode, `done` is first high right after the 32nd rising edge that follows the edge accepting `start`, and it is high for exactly one cycle.
- R4: In signed mode (`signedMode`=1), when `done` is high, {`resHi`,`resLo`} equals the 64-bit two's-complement product of the operands. This includes an operand of 0x80000000 and operands whose signs differ.
- R5: In signed mode, `done` is first high right after the 33rd rising edge that follows the accepting edge: 31 iterations, one sign-position step and one sign-fix cycle.
- R6: `busy` is high from the edge that accepts `start` until the edge that raises `done`. While `busy` is high, `start`, `opA`, `opB` and `signedMode` are ignored: the result and the latency are those of the operation already in progress.
- R7: The carry out of the 32-bit add enters bit 63 on the same shift, so that 0xFFFFFFFF times 0xFFFFFFFF unsigned gives `resHi`=0xFFFFFFFE and `resLo`=0x00000001.
- R8: After `done`, `resHi` and `resLo` stay unchanged until another `start` is accepted, whatever happens on the operand inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Starts an operation when the unit is idle |
| signedMode | input | 1 | 1 selects a two's-complement product, 0 an unsigned product |
| opA | input | 32 | Multiplicand |
| opB | input | 32 | Multiplier |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle pulse when the result is ready |
| resHi | output | 32 | Upper 32 bits of the product |
| resLo | output | 32 | Lower 32 bits of the product |

## Verification
The bench aims at the all-ones operand. If the carry out of the half-width adder were dropped, that operand would give a wrong `resHi` in unsigned mode. In signed mode the same value stands for -1, and a missing or misapplied sign fix would flip the sign of the result. Operands of 0x80000000 test the sign-position step: a design that skipped it would return zero for a product that is in fact nonzero. The bench also pulses `start` and changes the operands and the mode in the middle of an operation. A unit that restarted, or that read the mode while busy, would show the wrong product or the wrong latency.

// File: rtl/mul_pkg.sv
package mul_pkg;

  // Strobes that the sequencer drives into the datapath
  typedef struct packed {
    logic load;    // capture operands, clear upper half
    logic step;    // conditional add then right shift
    logic negate;  // two's-complement the product if signs differ
  } mulStrobeT;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_RUN     = 2'd1,
    ST_SIGNPOS = 2'd2,
    ST_FIXSIGN = 2'd3
  } mulStateT;

endpackage

// File: rtl/mul_half_adder.sv
module mul_half_adder #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] addA,
  input  logic [WIDTH-1:0] addB,
  output logic [WIDTH-1:0] sum,
  output logic             carryOut
);

  logic [WIDTH:0] wide;

  always_comb begin
    wide     = {1'b0, addA} + {1'b0, addB};
    sum      = wide[WIDTH-1:0];
    carryOut = wide[WIDTH];
  end

endmodule

// File: rtl/mul_datapath.sv
module mul_datapath
  import mul_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  mulStrobeT        strobes,
  input  logic             signedMode,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  output logic [WIDTH-1:0] prodHi,
  output logic [WIDTH-1:0] prodLo
);

  localparam int PW = 2 * WIDTH;

  logic [WIDTH-1:0] mcandQ;
  logic [PW-1:0]    prodQ;
  logic             negQ;

  logic [WIDTH-1:0] magA, magB;
  logic [WIDTH-1:0] addSum;
  logic             addCarry;

  // Magnitudes are formed only in signed mode; unsigned operands pass through
  always_comb begin
    magA = (signedMode && opA[WIDTH-1]) ? (~opA + 1'b1) : opA;
    magB = (signedMode && opB[WIDTH-1]) ? (~opB + 1'b1) : opB;
  end

  mul_half_adder #(.WIDTH(WIDTH)) uAdder (
    .addA    (prodQ[PW-1:WIDTH]),
    .addB    (mcandQ),
    .sum     (addSum),
    .carryOut(addCarry)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mcandQ <= '0;
      prodQ  <= '0;
      negQ   <= 1'b0;
    end else if (strobes.load) begin
      mcandQ <= magA;
      prodQ  <= {{WIDTH{1'b0}}, magB};
      negQ   <= signedMode & (opA[WIDTH-1] ^ opB[WIDTH-1]);
    end else if (strobes.step) begin
      if (prodQ[0])
        prodQ <= {addCarry, addSum, prodQ[WIDTH-1:1]};
      else
        prodQ <= {1'b0, prodQ[PW-1:1]};
    end else if (strobes.negate && negQ) begin
      prodQ <= ~prodQ + 1'b1;
    end
  end

  assign prodHi = prodQ[PW-1:WIDTH];
  assign prodLo = prodQ[WIDTH-1:0];

endmodule

// File: rtl/mul_ctrl.sv
module mul_ctrl
  import mul_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      start,
  input  logic      signedMode,
  output mulStrobeT strobes,
  output logic      busy,
  output logic      done
);

  localparam int CNTW = $clog2(WIDTH);
  localparam logic [CNTW-1:0] LAST_UNS = CNTW'(WIDTH - 1);
  localparam logic [CNTW-1:0] LAST_SGN = CNTW'(WIDTH - 2);

  mulStateT        stateQ;
  logic [CNTW-1:0] cntQ;
  logic            sgnQ;
  logic            doneQ;
  logic            lastIter;

  assign lastIter = (cntQ == (sgnQ ? LAST_SGN : LAST_UNS));

  always_comb begin
    strobes.load   = (stateQ == ST_IDLE) && start;
    strobes.step   = (stateQ == ST_RUN) || (stateQ == ST_SIGNPOS);
    strobes.negate = (stateQ == ST_FIXSIGN);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      cntQ   <= '0;
      sgnQ   <= 1'b0;
      doneQ  <= 1'b0;
    end else begin
      doneQ <= 1'b0;
      case (stateQ)
        ST_IDLE: begin
          if (start) begin
            stateQ <= ST_RUN;
            cntQ   <= '0;
            sgnQ   <= signedMode;
          end
        end
        ST_RUN: begin
          cntQ <= cntQ + 1'b1;
          if (lastIter) begin
            stateQ <= sgnQ ? ST_SIGNPOS : ST_IDLE;
            doneQ  <= ~sgnQ;
          end
        end
        ST_SIGNPOS: stateQ <= ST_FIXSIGN;
        ST_FIXSIGN: begin
          stateQ <= ST_IDLE;
          doneQ  <= 1'b1;
        end
        default: stateQ <= ST_IDLE;
      endcase
    end
  end

  assign busy = (stateQ != ST_IDLE);
  assign done = doneQ;

endmodule

// File: rtl/shift_add_mul.sv
module shift_add_mul
  import mul_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             signedMode,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  output logic             busy,
  output logic             done,
  output logic [WIDTH-1:0] resHi,
  output logic [WIDTH-1:0] resLo
);

  mulStrobeT strobes;

  mul_ctrl #(.WIDTH(WIDTH)) uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .start     (start),
    .signedMode(signedMode),
    .strobes   (strobes),
    .busy      (busy),
    .done      (done)
  );

  mul_datapath #(.WIDTH(WIDTH)) uPath (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .signedMode(signedMode),
    .opA       (opA),
    .opB       (opB),
    .prodHi    (resHi),
    .prodLo    (resLo)
  );

endmodule

// File: rtl/mul_checker.sv
module mul_checker #(
  parameter int WIDTH = 32
) (
  input logic             clk,
  input logic             rstN,
  input logic             start,
  input logic             signedMode,
  input logic             busy,
  input logic             done,
  input logic [WIDTH-1:0] resHi,
  input logic [WIDTH-1:0] resLo
);

  // Edge counter from the accepting edge, checked against the expected latency
  logic [7:0] latCnt;
  logic       sgnL;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      latCnt <= '0;
      sgnL   <= 1'b0;
    end else if (!busy && start) begin
      latCnt <= '0;
      sgnL   <= signedMode;
    end else if (busy) begin
      latCnt <= latCnt + 1'b1;
    end
  end

  // R3: done lasts exactly one cycle
  a_r3_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R3 and R5: latency of 32 (unsigned) or 33 (signed) edges
  a_r3_latency: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (latCnt == (sgnL ? 8'd33 : 8'd32)));

  // R6: an accepted start makes the unit busy
  a_r6_busy_on_start: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && start) |=> busy);

  // R6: busy falls only together with done
  a_r6_busy_ends_done: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> done);

  // R8: results hold while idle and no start is given
  a_r8_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !start) |=> ($stable(resHi) && $stable(resLo)));

  // R1: outputs are clear while in reset
  always_comb begin
    if (!rstN) begin
      a_r1_reset: assert (!busy && !done && resHi == '0 && resLo == '0);
    end
  end

endmodule

bind shift_add_mul mul_checker #(.WIDTH(WIDTH)) uChk (
  .clk       (clk),
  .rstN      (rstN),
  .start     (start),
  .signedMode(signedMode),
  .busy      (busy),
  .done      (done),
  .resHi     (resHi),
  .resLo     (resLo)
);

// File: tb/sim_shift_add_mul.sv
module sim_shift_add_mul;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic        signedMode = 1'b0;
  logic [31:0] opA = '0;
  logic [31:0] opB = '0;
  logic        busy, done;
  logic [31:0] resHi, resLo;

  int errors = 0;
  int checks = 0;

  always #4 clk = ~clk;  // 125 MHz

  shift_add_mul u0 (
    .clk(clk), .rstN(rstN), .start(start), .signedMode(signedMode),
    .opA(opA), .opB(opB), .busy(busy), .done(done),
    .resHi(resHi), .resLo(resLo)
  );

  // Stimulus table: {mode, opA, opB}; expected product comes from refMul
  localparam logic [64:0] TBL [14] = '{
    {1'b0, 32'h0000_0000, 32'h0000_0000},
    {1'b0, 32'h0000_0001, 32'hFFFF_FFFF},
    {1'b0, 32'hFFFF_FFFF, 32'h0000_0001},
    {1'b0, 32'hFFFF_FFFF, 32'h0000_0000},
    {1'b0, 32'h8000_0000, 32'h8000_0000},
    {1'b0, 32'h1234_5678, 32'h9ABC_DEF0},
    {1'b1, 32'h0000_0000, 32'hFFFF_FFFF},
    {1'b1, 32'hFFFF_FFFF, 32'hFFFF_FFFF},
    {1'b1, 32'h0000_0001, 32'hFFFF_FFFF},
    {1'b1, 32'h8000_0000, 32'h0000_0001},
    {1'b1, 32'h0000_0003, 32'h8000_0000},
    {1'b1, 32'h8000_0000, 32'h8000_0000},
    {1'b1, 32'h8000_0000, 32'hFFFF_FFFF},
    {1'b1, 32'hFFFF_FFF9, 32'h0000_0002}
  };

  function automatic logic [63:0] refMul(input logic m, input logic [31:0] a,
                                         input logic [31:0] b);
    logic signed [63:0] sa, sb;
    if (m) begin
      sa = $signed({{32{a[31]}}, a});
      sb = $signed({{32{b[31]}}, b});
      return 64'(sa * sb);
    end
    return {32'b0, a} * {32'b0, b};
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Runs one operation; optionally disturbs inputs while busy
  task automatic runOp(input logic m, input logic [31:0] a, input logic [31:0] b,
                       input bit poke);
    int edges;
    logic [63:0] exp;
    exp = refMul(m, a, b);
    @(negedge clk);
    signedMode = m; opA = a; opB = b; start = 1'b1;
    @(posedge clk);
    edges = 0;
    forever begin
      @(negedge clk);
      start = 1'b0;
      if (edges == 1) chk("R6 busy", 64'(busy), 64'd1);
      if (poke && edges == 4) begin
        start = 1'b1; signedMode = ~m; opA = ~a; opB = b ^ 32'h5A5A_5A5A;
      end
      if (done || edges > 60) break;
      @(posedge clk);
      edges++;
    end
    chk(m ? "R4 product" : "R2 product", {resHi, resLo}, exp);
    chk(m ? "R5 latency" : "R3 latency", 64'(edges), m ? 64'd33 : 64'd32);
    @(negedge clk);
    chk("R3 done single", 64'(done), 64'd0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    logic [31:0] ra, rb;
    logic [63:0] held;
    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1 busy", 64'(busy), 64'd0);
    chk("R1 done", 64'(done), 64'd0);
    chk("R1 result", {resHi, resLo}, 64'd0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 after release", {62'd0, busy, done}, 64'd0);

    for (int i = 0; i < 14; i++)
      runOp(TBL[i][64], TBL[i][63:32], TBL[i][31:0], 1'b0);

    // R7: carry into bit 63
    runOp(1'b0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0);
    chk("R7 carry", {resHi, resLo}, 64'hFFFF_FFFE_0000_0001);

    // R4: all-ones as -1 in signed mode gives +1
    runOp(1'b1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0);
    chk("R4 minus one squared", {resHi, resLo}, 64'h0000_0000_0000_0001);

    // R6: start, operands and mode ignored while busy
    runOp(1'b0, 32'hDEAD_BEEF, 32'h0000_1001, 1'b1);
    runOp(1'b1, 32'hF000_0001, 32'h0123_4567, 1'b1);

    // R8: result held after done while inputs change
    held = {resHi, resLo};
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      opA = 32'(k * 77); opB = ~opA; signedMode = ~signedMode;
    end
    chk("R8 hold", {resHi, resLo}, held);

    // R2/R4: pseudo-random operands in both modes
    ra = 32'h1357_9BDF;
    rb = 32'h2468_ACE0;
    for (int k = 0; k < 40; k++) begin
      ra = ra * 32'd1664525 + 32'd1013904223;
      rb = rb ^ (rb << 13); rb = rb ^ (rb >> 17); rb = rb ^ (rb << 5);
      runOp(k[0], ra, rb, 1'b0);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule